// File: doc/BRIEF.md
# DMA Channel Interrupt-Coalescing Controller

This block keeps the software-visible control and status state of a single DMA channel: the run, halt and idle state, the descriptor pointers handed to the transfer engine, and the logic that decides when the channel interrupts. The transfer engine itself sits outside. It reports its progress to this block through one-cycle pulses: a descriptor finished, an error occurred, the tail descriptor was reached, or the engine halted. In return, a tail-pointer write sends the engine a one-cycle start pulse.

Interrupts are coalesced in two ways. A completion counter raises the completion flag once a programmable number of descriptors has finished. A delay timer is restarted by every completion and raises the delay flag when it runs out, so a short burst that never reaches the count is still reported. The timer counts ticks from an internal prescaler whose period is a parameter. Software reads the live counter and the live timer back in the upper fields of the control register. The interrupt line is the masked OR of the three status flags.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset the status register reads 0x0000_0001, the control register reads 0x0001_0002, irq is 0 and both pointer outputs are 0.
- R2: Control bit 1 always reads 1 and control bit 2 always reads 0, whatever was written.
- R3: A control write with bit 2 set performs a soft reset. The status becomes 0x0000_0001, the threshold becomes 1, the delay becomes 0, the counter becomes 1 and the timer becomes 0. The reset stays pending until the next control read. While it is pending, a write with bit 0 set changes neither status bits 1:0 nor the counter.
- R4: A control write with bit 0 set, with bit 2 clear and no reset pending, clears status bits 0 (halted) and 1 (idle) and loads the counter from write bits 23:16.
- R5: Writing 1 to status bit 12, 13 or 14 clears that flag. All other status bits take the written value.
- R6: irq is 1 exactly when (status[14:12] AND control[14:12]) is nonzero.
- R7: On a completion pulse, a nonzero delay field (control bits 31:24) reloads the timer with that value. The counter then decrements. If the counter held 1 or 0, status bit 12 is set and the counter reloads from the threshold (control bits 23:16) instead.
- R8: The timer decrements once every TICK_DIV cycles while it is nonzero, and a value of 0 means it is stopped. A step from 1 to 0 sets status bit 13 and reloads the counter from the threshold. A completion in the same cycle takes priority.
- R9: A control read returns the written bits 15:0, the live counter in bits 23:16 and the live timer in bits 31:24.
- R10: A write to offset 0x10 stores the tail pointer, clears status bit 1, and raises start_pulse for exactly the next cycle.
- R11: Offset 0x08 holds the current-descriptor pointer, and 0x08 and 0x10 read back what was written. Both pointers are driven on outputs.
- R12: An err_evt pulse sets status bit 14, a tail_evt pulse sets status bit 1 and a halt_evt pulse sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a control read clears a pending soft reset) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cmpl_evt | input | 1 | Descriptor completed pulse |
| err_evt | input | 1 | Transfer error pulse |
| tail_evt | input | 1 | Tail descriptor reached pulse |
| halt_evt | input | 1 | Engine halted pulse |
| start_pulse | output | 1 | One-cycle start request to the engine |
| cur_ptr | output | PTR_W | Current-descriptor pointer |
| tail_ptr | output | PTR_W | Tail-descriptor pointer |
| irq | output | 1 | Level interrupt |

## Verification
The checker watches every cycle for the following. The start pulse only ever follows a tail write. A completion with a nonzero delay loads the timer. A timer running out sets the delay flag. A run write clears halted and idle. A run write during a pending soft reset leaves the counter and the state flags alone. Only the bench scenarios can show the rest: the exact completion count at which the flag rises, the timer restarting on each completion, the readback layout of the live fields, the write-one-to-clear behaviour, and the masking of the interrupt line.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
   localparam int REG_W    = 32;
   localparam int FLD_W    = 8;
   localparam int OFS_CTRL = 'h00;
   localparam int OFS_STAT = 'h04;
   localparam int OFS_CUR  = 'h08;
   localparam int OFS_TAIL = 'h10;
   localparam int CB_RUN   = 0;
   localparam int CB_TMODE = 1;
   localparam int CB_SRST  = 2;
   localparam int SB_HALT  = 0;
   localparam int SB_IDLE  = 1;
   localparam int SB_IOC   = 12;
   localparam int SB_DLY   = 13;
   localparam int SB_ERR   = 14;
   localparam int THR_LO   = 16;
   localparam int DLY_LO   = 24;
   localparam logic [REG_W-1:0] IRQ_BITS = 32'h0000_7000;
endpackage

// File: rtl/dma_tick_gen.sv
module dma_tick_gen #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_every
         logic unused_w;
         assign unused_w = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/dma_coalesce.sv
module dma_coalesce
   import dma_csr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             arm,
   input  logic [FLD_W-1:0] arm_val,
   input  logic [FLD_W-1:0] thr,
   input  logic [FLD_W-1:0] dly_val,
   input  logic             cmpl,
   input  logic             tick,
   output logic [FLD_W-1:0] cnt,
   output logic [FLD_W-1:0] timer,
   output logic             ioc_set,
   output logic             dly_set
);
   logic restart;
   logic expire;
   logic cnt_last;

   assign restart  = cmpl && (dly_val != '0);
   assign cnt_last = (cnt <= FLD_W'(1));
   assign expire   = tick && (timer == FLD_W'(1)) && !restart && !soft_rst;
   assign ioc_set  = cmpl && cnt_last && !arm && !soft_rst;
   assign dly_set  = expire;

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         timer <= '0;
      end else if (restart) begin
         timer <= dly_val;
      end else if (tick && timer != '0) begin
         timer <= timer - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         cnt <= FLD_W'(1);
      end else if (arm) begin
         cnt <= arm_val;
      end else if (cmpl) begin
         cnt <= cnt_last ? thr : cnt - 1'b1;
      end else if (expire) begin
         cnt <= thr;
      end
   end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
   import dma_csr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PTR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              err_evt,
   input  logic              tail_evt,
   input  logic              halt_evt,
   input  logic              ioc_set,
   input  logic              dly_set,
   output logic              soft_rst,
   output logic              arm,
   output logic [FLD_W-1:0]  arm_val,
   output logic [FLD_W-1:0]  thr,
   output logic [FLD_W-1:0]  dly_val,
   output logic [15:0]       ctrl_lo,
   output logic              rst_pend,
   output logic [REG_W-1:0]  status,
   output logic [PTR_W-1:0]  cur_ptr,
   output logic [PTR_W-1:0]  tail_ptr,
   output logic              start_pulse
);
   logic sel_ctrl, sel_stat, sel_cur, sel_tail;
   logic [REG_W-1:0] stat_n;

   assign sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
   assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
   assign sel_cur  = (reg_addr == ADDR_W'(OFS_CUR));
   assign sel_tail = (reg_addr == ADDR_W'(OFS_TAIL));

   assign soft_rst = reg_wr && sel_ctrl && reg_wdata[CB_SRST];
   assign arm      = reg_wr && sel_ctrl && reg_wdata[CB_RUN]
                     && !reg_wdata[CB_SRST] && !rst_pend;
   assign arm_val  = reg_wdata[THR_LO +: FLD_W];

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         ctrl_lo <= 16'h0002;
         thr     <= FLD_W'(1);
         dly_val <= '0;
      end else if (reg_wr && sel_ctrl) begin
         ctrl_lo <= (reg_wdata[15:0] | 16'h0002) & ~16'h0004;
         thr     <= reg_wdata[THR_LO +: FLD_W];
         dly_val <= reg_wdata[DLY_LO +: FLD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      rst_pend <= 1'b0;
      else if (soft_rst)               rst_pend <= 1'b1;
      else if (reg_rd && sel_ctrl)     rst_pend <= 1'b0;
   end

   always_comb begin
      stat_n = status;
      if (reg_wr && sel_stat)
         stat_n = (reg_wdata & ~IRQ_BITS) | (status & IRQ_BITS & ~reg_wdata);
      if (arm) begin
         stat_n[SB_HALT] = 1'b0;
         stat_n[SB_IDLE] = 1'b0;
      end
      if (reg_wr && sel_tail) stat_n[SB_IDLE] = 1'b0;
      if (ioc_set)  stat_n[SB_IOC]  = 1'b1;
      if (dly_set)  stat_n[SB_DLY]  = 1'b1;
      if (err_evt)  stat_n[SB_ERR]  = 1'b1;
      if (tail_evt) stat_n[SB_IDLE] = 1'b1;
      if (halt_evt) stat_n[SB_HALT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) status <= REG_W'(1);
      else                    status <= stat_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_ptr     <= '0;
         tail_ptr    <= '0;
         start_pulse <= 1'b0;
      end else begin
         start_pulse <= reg_wr && sel_tail;
         if (reg_wr && sel_cur)  cur_ptr  <= reg_wdata[PTR_W-1:0];
         if (reg_wr && sel_tail) tail_ptr <= reg_wdata[PTR_W-1:0];
      end
   end
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
   import dma_csr_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int PTR_W    = 32,
   parameter int TICK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cmpl_evt,
   input  logic              err_evt,
   input  logic              tail_evt,
   input  logic              halt_evt,
   output logic              start_pulse,
   output logic [PTR_W-1:0]  cur_ptr,
   output logic [PTR_W-1:0]  tail_ptr,
   output logic              irq
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x10");
      end
      if (PTR_W < 1 || PTR_W > REG_W) begin : g_bad_ptr
         $error("PTR_W must lie in 1..32");
      end
   endgenerate

   logic             tick_w, soft_rst, arm, ioc_set, dly_set, rst_pend;
   logic [FLD_W-1:0] arm_val, thr, dly_field, coal_cnt, dly_timer;
   logic [15:0]      ctrl_lo;
   logic [REG_W-1:0] stat_q;

   dma_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick_w)
   );

   dma_ctrl_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .err_evt(err_evt), .tail_evt(tail_evt), .halt_evt(halt_evt),
      .ioc_set(ioc_set), .dly_set(dly_set),
      .soft_rst(soft_rst), .arm(arm), .arm_val(arm_val), .thr(thr),
      .dly_val(dly_field), .ctrl_lo(ctrl_lo), .rst_pend(rst_pend),
      .status(stat_q), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr),
      .start_pulse(start_pulse)
   );

   dma_coalesce u_coal (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .arm(arm),
      .arm_val(arm_val), .thr(thr), .dly_val(dly_field),
      .cmpl(cmpl_evt), .tick(tick_w), .cnt(coal_cnt), .timer(dly_timer),
      .ioc_set(ioc_set), .dly_set(dly_set)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_CTRL))
         reg_rdata = {dly_timer, coal_cnt, ctrl_lo};
      else if (reg_addr == ADDR_W'(OFS_STAT))
         reg_rdata = stat_q;
      else if (reg_addr == ADDR_W'(OFS_CUR))
         reg_rdata = REG_W'(cur_ptr);
      else if (reg_addr == ADDR_W'(OFS_TAIL))
         reg_rdata = REG_W'(tail_ptr);
   end

   assign irq = |(stat_q[SB_ERR:SB_IOC] & ctrl_lo[SB_ERR:SB_IOC]);
endmodule

// File: rtl/dma_irq_coalesce_chk.sv
module dma_irq_coalesce_chk
   import dma_csr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              cmpl_evt,
   input logic              tail_evt,
   input logic              halt_evt,
   input logic              tick,
   input logic              start_pulse,
   input logic              rst_pend,
   input logic [7:0]        timer,
   input logic [7:0]        dly_val,
   input logic [7:0]        cnt,
   input logic [31:0]       status
);
   logic wr_ctrl;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

   a_r10_start_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(reg_wr && reg_addr == ADDR_W'(OFS_TAIL)));

   a_r7_timer_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_evt && dly_val != 8'd0 && !wr_ctrl) |=> timer == $past(dly_val));

   a_r8_expiry_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && timer == 8'd1 && !cmpl_evt && !reg_wr) |=> status[SB_DLY]);

   a_r4_run_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[CB_RUN] && !reg_wdata[CB_SRST] && !rst_pend
       && !halt_evt && !tail_evt) |=> status[1:0] == 2'b00);

   a_r3_run_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && rst_pend && reg_wdata[CB_RUN] && !reg_wdata[CB_SRST]
       && !halt_evt && !tail_evt && !cmpl_evt && !tick)
      |=> (status[1:0] == $past(status[1:0])) && (cnt == $past(cnt)));
endmodule

bind dma_irq_coalesce dma_irq_coalesce_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .cmpl_evt(cmpl_evt), .tail_evt(tail_evt),
   .halt_evt(halt_evt), .tick(tick_w), .start_pulse(start_pulse),
   .rst_pend(rst_pend), .timer(dly_timer), .dly_val(dly_field),
   .cnt(coal_cnt), .status(stat_q)
);

// File: tb/sim_dma_irq_coalesce.sv
module sim_dma_irq_coalesce;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_CUR = 8'h08, A_TAIL = 8'h10;

   typedef struct packed {
      logic        is_rd;
      logic [7:0]  addr;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b1, A_CTRL, 32'h0001_0002},  // R1 R2 reset control
      '{1'b1, A_STAT, 32'h0000_0001},  // R1 reset status
      '{1'b0, A_CUR,  32'h0000_1000},
      '{1'b1, A_CUR,  32'h0000_1000},  // R11
      '{1'b0, A_TAIL, 32'h0000_2000},
      '{1'b1, A_TAIL, 32'h0000_2000},  // R10 R11
      '{1'b0, A_STAT, 32'h0000_0F02},
      '{1'b1, A_STAT, 32'h0000_0F02},  // R5 plain bits stored
      '{1'b0, A_STAT, 32'h0000_0001},
      '{1'b1, A_STAT, 32'h0000_0001},  // R5
      '{1'b0, A_CTRL, 32'h0003_7001},
      '{1'b1, A_CTRL, 32'h0003_7003},  // R4 R9 counter loaded
      '{1'b1, A_STAT, 32'h0000_0000}   // R4 halted/idle cleared
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic cmpl_evt = 1'b0, err_evt = 1'b0, tail_evt = 1'b0, halt_evt = 1'b0;
   logic start_pulse, irq;
   logic [31:0] cur_ptr, tail_ptr;
   int nchk = 0, nfail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_irq_coalesce #(.ADDR_W(8), .PTR_W(32), .TICK_DIV(4)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cmpl_evt(cmpl_evt), .err_evt(err_evt), .tail_evt(tail_evt),
      .halt_evt(halt_evt), .start_pulse(start_pulse), .cur_ptr(cur_ptr),
      .tail_ptr(tail_ptr), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      reg_rd = 1'b1; reg_addr = a;
      #1 chk(tag, reg_rdata, exp);
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input int sel);
      cmpl_evt = (sel == 0); err_evt = (sel == 1);
      tail_evt = (sel == 2); halt_evt = (sel == 3);
      @(posedge clk); @(negedge clk);
      cmpl_evt = 1'b0; err_evt = 1'b0; tail_evt = 1'b0; halt_evt = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 cur_ptr", cur_ptr, 32'd0);
      chk("R1 tail_ptr", tail_ptr, 32'd0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_rd) rd($sformatf("vector %0d", i), VEC[i].addr, VEC[i].data);
         else              wr(VEC[i].addr, VEC[i].data);
      end
      chk("R11 cur_ptr out", cur_ptr, 32'h1000);

      // R7 completion count threshold 3
      pulse(0); pulse(0);
      chk("R7 no irq before count", {31'd0, irq}, 32'd0);
      rd("R7 R9 counter 1", A_CTRL, 32'h0001_7003);
      pulse(0);
      rd("R7 ioc flag", A_STAT, 32'h0000_1000);
      chk("R6 irq on ioc", {31'd0, irq}, 32'd1);
      rd("R7 counter reload", A_CTRL, 32'h0003_7003);
      wr(A_STAT, 32'h0000_1000);
      chk("R5 R6 w1c irq", {31'd0, irq}, 32'd0);
      rd("R5 w1c status", A_STAT, 32'h0);

      // R8 delay timer
      wr(A_CTRL, 32'h0505_7001);
      pulse(0);
      rd("R7 R9 timer loaded", A_CTRL, 32'h0504_7003);
      repeat (40) @(negedge clk);
      rd("R8 delay flag", A_STAT, 32'h0000_2000);
      chk("R6 irq on delay", {31'd0, irq}, 32'd1);
      rd("R8 counter reload on expiry", A_CTRL, 32'h0005_7003);
      wr(A_STAT, 32'h0000_2000);
      pulse(0);
      repeat (12) @(negedge clk);
      rd("R8 not yet expired", A_STAT, 32'h0);
      pulse(0);
      rd("R7 timer restarted", A_CTRL, 32'h0503_7003);
      repeat (40) @(negedge clk);
      wr(A_STAT, 32'h0000_2000);

      // R7 threshold zero fires on every completion
      wr(A_CTRL, 32'h0000_7001);
      pulse(0);
      rd("R7 threshold zero", A_STAT, 32'h0000_1000);
      wr(A_STAT, 32'h0000_1000);

      // R12 error, R6 masking
      pulse(1);
      rd("R12 err flag", A_STAT, 32'h0000_4000);
      chk("R6 irq on err", {31'd0, irq}, 32'd1);
      wr(A_CTRL, 32'h0000_0001);
      chk("R6 masked irq", {31'd0, irq}, 32'd0);
      rd("R6 flag kept while masked", A_STAT, 32'h0000_4000);
      wr(A_STAT, 32'h0000_4000);

      // R12 tail reached, R10 start pulse
      pulse(2);
      rd("R12 idle set", A_STAT, 32'h0000_0002);
      wr(A_TAIL, 32'h0000_3000);
      chk("R10 start high", {31'd0, start_pulse}, 32'd1);
      @(negedge clk);
      chk("R10 start one cycle", {31'd0, start_pulse}, 32'd0);
      rd("R10 idle cleared", A_STAT, 32'h0);
      chk("R10 tail_ptr out", tail_ptr, 32'h3000);
      pulse(3);
      rd("R12 halt set", A_STAT, 32'h0000_0001);

      // R3 soft reset
      wr(A_CTRL, 32'h0909_7005);
      wr(A_CTRL, 32'h0004_0001);
      rd("R3 run ignored", A_STAT, 32'h0000_0001);
      rd("R3 R2 after soft reset", A_CTRL, 32'h0001_0003);
      wr(A_CTRL, 32'h0004_0001);
      rd("R4 run after read", A_STAT, 32'h0);
      rd("R4 counter loaded", A_CTRL, 32'h0004_0003);
      wr(A_CTRL, 32'h0000_0000);
      rd("R2 mode bit forced", A_CTRL, 32'h0004_0002);

      finish_run();
   end
endmodule